// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block parks the device in one of two reduced-power depths when a power-save command arrives, and returns it to normal running when a wake condition occurs. The command carries a one-bit mode code. The deeper depth, Sleep, stops the system oscillator. With the oscillator off, the CPU and every peripheral clocked from the system clock also stop. The shallower depth, Idle, gates only the CPU clock. The system oscillator keeps running in Idle, and each peripheral keeps its clock unless software has set that peripheral's idle mask bit.

A wake can come from an interrupt request whose enable bit is set, or from a watchdog timeout. A device reset also returns the block to running. At Sleep entry the block records the clock-source selection. On wake from Sleep it restarts that recorded source, even if the live selection has changed since entry. It then holds the CPU clock off until the oscillator reports that it is ready. The clock-fail monitor is held off while the system clock is stopped. The watchdog receives a clear pulse on Sleep entry. A set of sticky flags records the cause and the depth of the last wake, and software clears these flags one bit at a time.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A command (`cmd_valid_i`=1) accepted while running enters Sleep when `cmd_mode_i`=1 and Idle when `cmd_mode_i`=0. The state changes on the next clock edge. A command given in any other state is ignored.
- R2: In Sleep, `osc_en_o`, `periph_clk_en_o` and `cpu_clk_en_o` are all zero.
- R3: In Idle, `cpu_clk_en_o`=0, `osc_en_o` is one-hot on the live `clk_src_sel_i`, and `periph_clk_en_o` is the bitwise inverse of the peripheral idle mask.
- R4: Sleep and Idle are left on the clock edge at which `|(irq_i & irq_en_i)` or `wdt_timeout_i` is high. An interrupt request whose enable bit is 0 has no effect.
- R5: On wake from Sleep, `osc_en_o` is one-hot on the source that was latched at Sleep entry. `cpu_clk_en_o` stays 0 until the clock edge that samples `osc_ready_i`=1.
- R6: `clk_mon_en_o` is 0 in Sleep and while waiting for the oscillator after Sleep, and 1 otherwise.
- R7: `wdt_clr_o` is high for exactly the first cycle of Sleep and is never high otherwise.
- R8: `wake_flags_o` has bit0 = interrupt wake, bit1 = watchdog wake, bit2 = woke from Sleep, bit3 = woke from Idle. All four bits are overwritten on each wake. Writing a 1 to bit n of `flag_clr_i` clears flag n. If a wake and a clear happen in the same cycle, the wake wins.
- R9: An asserted `rst_ni` returns the block to running at once, without waiting for a clock edge. It also clears all idle mask bits and all wake flags.
- R10: While running, `cpu_clk_en_o`=1, all `periph_clk_en_o` bits are 1, and `osc_en_o` is one-hot on `clk_src_sel_i`.
- R11: `idle_mask_wr_i`=1 loads `idle_mask_i` into the idle mask on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Power-save command strobe |
| cmd_mode_i | input | 1 | Mode code: 1 = Sleep, 0 = Idle |
| irq_i | input | N_IRQ | Interrupt requests |
| irq_en_i | input | N_IRQ | Per-interrupt enables |
| wdt_timeout_i | input | 1 | Watchdog timeout |
| clk_src_sel_i | input | SRC_W | Live clock-source selection |
| osc_ready_i | input | 1 | Selected oscillator is stable |
| idle_mask_wr_i | input | 1 | Load strobe for the idle mask |
| idle_mask_i | input | N_PERIPH | Per-peripheral idle mask (1 = stop in Idle) |
| flag_clr_i | input | 4 | Per-bit clear of the wake flags |
| osc_en_o | output | N_SRC | One-hot oscillator enables |
| cpu_clk_en_o | output | 1 | CPU clock gate |
| periph_clk_en_o | output | N_PERIPH | Peripheral clock gates |
| clk_mon_en_o | output | 1 | Clock-fail monitor enable |
| wdt_clr_o | output | 1 | Watchdog clear on Sleep entry |
| wake_flags_o | output | 4 | Wake cause and depth flags |

## Verification
A wrong state register shows up at the ports in the first cycle after the edge that caused it. The gate outputs are decoded straight from the state, so a missed Sleep entry leaves `osc_en_o` non-zero and `wdt_clr_o` low in that cycle. A lost latched source shows as the wrong one-hot `osc_en_o` during the oscillator wait. A premature return to running raises `cpu_clk_en_o` before `osc_ready_i` has been seen. Flag corruption appears on `wake_flags_o` one cycle after the wake edge or the clear edge.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } pwr_state_e;

  localparam logic MODE_SLEEP = 1'b1;
  localparam logic MODE_IDLE  = 1'b0;

  localparam int FLAG_IRQ   = 0;
  localparam int FLAG_WDT   = 1;
  localparam int FLAG_SLEEP = 2;
  localparam int FLAG_IDLE  = 3;
  localparam int N_FLAGS    = 4;
endpackage

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int SRC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_mode_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic              wdt_timeout_i,
  input  logic [SRC_W-1:0]  clk_src_sel_i,
  input  logic              osc_ready_i,
  output pwr_state_e        state_o,
  output logic [SRC_W-1:0]  saved_src_o,
  output logic              wdt_clr_o,
  output logic              wake_fire_o,
  output logic              wake_irq_o,
  output logic              wake_wdt_o,
  output logic              wake_from_sleep_o
);
  pwr_state_e state_q;
  logic [SRC_W-1:0] saved_q;
  logic wdt_clr_q;
  logic irq_hit, wake_req, low_power;

  assign irq_hit   = |(irq_i & irq_en_i);
  assign wake_req  = irq_hit | wdt_timeout_i;
  assign low_power = (state_q == ST_SLEEP) || (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      saved_q   <= '0;
      wdt_clr_q <= 1'b0;
    end else begin
      wdt_clr_q <= 1'b0;
      unique case (state_q)
        ST_RUN: if (cmd_valid_i) begin
          if (cmd_mode_i == MODE_SLEEP) begin
            state_q   <= ST_SLEEP;
            saved_q   <= clk_src_sel_i;
            wdt_clr_q <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_IDLE:  if (wake_req) state_q <= ST_RUN;
        ST_SLEEP: if (wake_req) state_q <= ST_WAKE;
        ST_WAKE:  if (osc_ready_i) state_q <= ST_RUN;
        default:  state_q <= ST_RUN;
      endcase
    end
  end

  assign state_o           = state_q;
  assign saved_src_o       = saved_q;
  assign wdt_clr_o         = wdt_clr_q;
  assign wake_fire_o       = low_power & wake_req;
  assign wake_irq_o        = irq_hit;
  assign wake_wdt_o        = wdt_timeout_i;
  assign wake_from_sleep_o = (state_q == ST_SLEEP);
endmodule

// File: rtl/pwr_wake_status.sv
module pwr_wake_status
  import pwr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wake_fire_i,
  input  logic               wake_irq_i,
  input  logic               wake_wdt_i,
  input  logic               wake_from_sleep_i,
  input  logic [N_FLAGS-1:0] clr_i,
  output logic [N_FLAGS-1:0] flags_o
);
  logic [N_FLAGS-1:0] flags_q, wake_val;

  always_comb begin
    wake_val             = '0;
    wake_val[FLAG_IRQ]   = wake_irq_i;
    wake_val[FLAG_WDT]   = wake_wdt_i;
    wake_val[FLAG_SLEEP] = wake_from_sleep_i;
    wake_val[FLAG_IDLE]  = ~wake_from_sleep_i;
  end

  // wake overrides a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flags_q <= '0;
    else if (wake_fire_i) flags_q <= wake_val;
    else                  flags_q <= flags_q & ~clr_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_pkg::*;
#(
  parameter int N_PERIPH = 6,
  parameter int N_SRC    = 4,
  parameter int SRC_W    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  pwr_state_e          state_i,
  input  logic [SRC_W-1:0]    live_src_i,
  input  logic [SRC_W-1:0]    saved_src_i,
  input  logic                mask_wr_i,
  input  logic [N_PERIPH-1:0] mask_i,
  output logic [N_SRC-1:0]    osc_en_o,
  output logic                cpu_clk_en_o,
  output logic [N_PERIPH-1:0] periph_clk_en_o,
  output logic                clk_mon_en_o
);
  logic [N_PERIPH-1:0] mask_q;
  logic [N_SRC-1:0] live_oh, saved_oh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_i;
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign live_oh[s]  = (live_src_i == SRC_W'(s));
    assign saved_oh[s] = (saved_src_i == SRC_W'(s));
  end

  always_comb begin
    osc_en_o        = live_oh;
    cpu_clk_en_o    = 1'b0;
    periph_clk_en_o = '0;
    clk_mon_en_o    = 1'b1;
    unique case (state_i)
      ST_RUN: begin
        cpu_clk_en_o    = 1'b1;
        periph_clk_en_o = '1;
      end
      ST_IDLE:  periph_clk_en_o = ~mask_q;
      ST_SLEEP: begin
        osc_en_o     = '0;
        clk_mon_en_o = 1'b0;
      end
      ST_WAKE: begin
        osc_en_o     = saved_oh;
        clk_mon_en_o = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int N_IRQ    = 8,
  parameter int N_PERIPH = 6,
  parameter int N_SRC    = 4,
  localparam int SRC_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic                cmd_mode_i,
  input  logic [N_IRQ-1:0]    irq_i,
  input  logic [N_IRQ-1:0]    irq_en_i,
  input  logic                wdt_timeout_i,
  input  logic [SRC_W-1:0]    clk_src_sel_i,
  input  logic                osc_ready_i,
  input  logic                idle_mask_wr_i,
  input  logic [N_PERIPH-1:0] idle_mask_i,
  input  logic [3:0]          flag_clr_i,
  output logic [N_SRC-1:0]    osc_en_o,
  output logic                cpu_clk_en_o,
  output logic [N_PERIPH-1:0] periph_clk_en_o,
  output logic                clk_mon_en_o,
  output logic                wdt_clr_o,
  output logic [3:0]          wake_flags_o
);
  pwr_state_e state;
  logic [SRC_W-1:0] saved_src;
  logic wake_fire, wake_irq, wake_wdt, wake_from_sleep;

  pwr_fsm #(.N_IRQ(N_IRQ), .SRC_W(SRC_W)) i_fsm (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_mode_i, .irq_i, .irq_en_i,
    .wdt_timeout_i, .clk_src_sel_i, .osc_ready_i,
    .state_o(state), .saved_src_o(saved_src), .wdt_clr_o,
    .wake_fire_o(wake_fire), .wake_irq_o(wake_irq), .wake_wdt_o(wake_wdt),
    .wake_from_sleep_o(wake_from_sleep)
  );

  pwr_wake_status i_status (
    .clk_i, .rst_ni, .wake_fire_i(wake_fire), .wake_irq_i(wake_irq),
    .wake_wdt_i(wake_wdt), .wake_from_sleep_i(wake_from_sleep),
    .clr_i(flag_clr_i), .flags_o(wake_flags_o)
  );

  pwr_clk_gate #(.N_PERIPH(N_PERIPH), .N_SRC(N_SRC), .SRC_W(SRC_W)) i_gate (
    .clk_i, .rst_ni, .state_i(state), .live_src_i(clk_src_sel_i),
    .saved_src_i(saved_src), .mask_wr_i(idle_mask_wr_i), .mask_i(idle_mask_i),
    .osc_en_o, .cpu_clk_en_o, .periph_clk_en_o, .clk_mon_en_o
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int N_PERIPH = 6,
  parameter int N_SRC    = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                osc_ready_i,
  input logic [N_SRC-1:0]    osc_en_o,
  input logic                cpu_clk_en_o,
  input logic [N_PERIPH-1:0] periph_clk_en_o,
  input logic                clk_mon_en_o,
  input logic                wdt_clr_o
);
  // R2
  sleep_gates_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |-> (osc_en_o == '0 && periph_clk_en_o == '0 && !cpu_clk_en_o));

  // R7
  wdt_clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> !wdt_clr_o);

  // R6
  mon_off_cpu_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_mon_en_o |-> !cpu_clk_en_o);

  // R5
  cpu_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_mon_en_o && osc_en_o != '0 && !osc_ready_i) |=> !cpu_clk_en_o);

  // R10
  run_all_periph_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> (&periph_clk_en_o && $onehot(osc_en_o)));

  // R3
  osc_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(osc_en_o));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_PERIPH(N_PERIPH), .N_SRC(N_SRC)) i_chk (
  .clk_i, .rst_ni, .osc_ready_i, .osc_en_o, .cpu_clk_en_o,
  .periph_clk_en_o, .clk_mon_en_o, .wdt_clr_o
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int N_IRQ = 8, N_PERIPH = 6, N_SRC = 4, SRC_W = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 0, cmd_mode_i = 0, wdt_timeout_i = 0, osc_ready_i = 0;
  logic [N_IRQ-1:0] irq_i = '0, irq_en_i = '0;
  logic [SRC_W-1:0] clk_src_sel_i = '0;
  logic idle_mask_wr_i = 0;
  logic [N_PERIPH-1:0] idle_mask_i = '0;
  logic [3:0] flag_clr_i = '0;
  logic [N_SRC-1:0] osc_en_o;
  logic cpu_clk_en_o, clk_mon_en_o, wdt_clr_o;
  logic [N_PERIPH-1:0] periph_clk_en_o;
  logic [3:0] wake_flags_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.N_IRQ(N_IRQ), .N_PERIPH(N_PERIPH), .N_SRC(N_SRC)) i_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni, .cmd_valid_i, .cmd_mode_i, .irq_i, .irq_en_i,
    .wdt_timeout_i, .clk_src_sel_i, .osc_ready_i, .idle_mask_wr_i, .idle_mask_i,
    .flag_clr_i, .osc_en_o, .cpu_clk_en_o, .periph_clk_en_o, .clk_mon_en_o,
    .wdt_clr_o, .wake_flags_o
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic run_state(string req, logic [SRC_W-1:0] sel);
    chk({req, " cpu"}, cpu_clk_en_o, 1);
    chk({req, " periph"}, periph_clk_en_o, 6'h3f);
    chk({req, " osc"}, osc_en_o, 4'b1 << sel);
    chk({req, " mon"}, clk_mon_en_o, 1);
  endtask

  task automatic t_reset();
    run_state("R10 reset", 0);
    chk("R9 flags", wake_flags_o, 0);
    chk("R7 wdt_clr idle", wdt_clr_o, 0);
  endtask

  task automatic t_idle();
    clk_src_sel_i = 1;
    idle_mask_wr_i = 1; idle_mask_i = 6'b000101;
    tick(); idle_mask_wr_i = 0;
    cmd_valid_i = 1; cmd_mode_i = 0;
    tick(); cmd_valid_i = 0;
    chk("R3 idle cpu", cpu_clk_en_o, 0);
    chk("R3 R11 idle periph", periph_clk_en_o, 6'b111010);
    chk("R3 idle osc", osc_en_o, 4'b0010);
    chk("R6 idle mon", clk_mon_en_o, 1);
    chk("R7 no clr in idle", wdt_clr_o, 0);
    // R1 second command ignored in idle
    cmd_valid_i = 1; cmd_mode_i = 1;
    tick(); cmd_valid_i = 0;
    chk("R1 cmd ignored clr", wdt_clr_o, 0);
    chk("R1 cmd ignored osc", osc_en_o, 4'b0010);
    // R4 disabled irq has no effect
    irq_i = 8'h10; irq_en_i = 8'h01;
    tick();
    chk("R4 masked irq cpu", cpu_clk_en_o, 0);
    chk("R4 masked irq flags", wake_flags_o, 0);
    irq_en_i = 8'h10;
    tick(); irq_i = '0; irq_en_i = '0;
    run_state("R4 idle wake", 1);
    chk("R8 idle irq flags", wake_flags_o, 4'b1001);
  endtask

  task automatic t_sleep();
    clk_src_sel_i = 2;
    cmd_valid_i = 1; cmd_mode_i = 1;
    tick(); cmd_valid_i = 0; clk_src_sel_i = 1;
    chk("R7 clr pulse", wdt_clr_o, 1);
    chk("R2 sleep osc", osc_en_o, 0);
    chk("R2 sleep periph", periph_clk_en_o, 0);
    chk("R2 sleep cpu", cpu_clk_en_o, 0);
    chk("R6 sleep mon", clk_mon_en_o, 0);
    tick();
    chk("R7 clr one cycle", wdt_clr_o, 0);
    chk("R2 sleep stays", osc_en_o, 0);
    wdt_timeout_i = 1; irq_i = 8'h02; irq_en_i = 8'h02;
    tick(); wdt_timeout_i = 0; irq_i = '0; irq_en_i = '0;
    chk("R5 saved src", osc_en_o, 4'b0100);
    chk("R5 cpu waits", cpu_clk_en_o, 0);
    chk("R6 wait mon", clk_mon_en_o, 0);
    chk("R8 sleep both flags", wake_flags_o, 4'b0111);
    tick();
    chk("R5 still waiting", cpu_clk_en_o, 0);
    osc_ready_i = 1;
    tick(); osc_ready_i = 0;
    run_state("R5 after ready", 1);
  endtask

  task automatic t_flags();
    flag_clr_i = 4'b0010;
    tick(); flag_clr_i = 0;
    chk("R8 bit clear", wake_flags_o, 4'b0101);
    // R4 wake sources while running leave flags alone
    wdt_timeout_i = 1;
    tick(); wdt_timeout_i = 0;
    chk("R8 run wake no flags", wake_flags_o, 4'b0101);
    cmd_valid_i = 1; cmd_mode_i = 0;
    tick(); cmd_valid_i = 0;
    wdt_timeout_i = 1; flag_clr_i = 4'hf;
    tick(); wdt_timeout_i = 0; flag_clr_i = 0;
    chk("R8 wake beats clear", wake_flags_o, 4'b1010);
  endtask

  task automatic t_reset_in_sleep();
    cmd_valid_i = 1; cmd_mode_i = 1;
    tick(); cmd_valid_i = 0;
    chk("R2 sleep before reset", cpu_clk_en_o, 0);
    #2 rst_ni = 0;
    #1;
    chk("R9 async run", cpu_clk_en_o, 1);
    chk("R9 flags cleared", wake_flags_o, 0);
    tick(); rst_ni = 1;
    tick();
    cmd_valid_i = 1; cmd_mode_i = 0;
    tick(); cmd_valid_i = 0;
    chk("R9 mask cleared", periph_clk_en_o, 6'h3f);
    chk("R3 idle after reset", cpu_clk_en_o, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    #1 t_reset();
    tick(); rst_ni = 1;
    tick();
    t_reset();
    t_idle();
    t_sleep();
    t_flags();
    t_reset_in_sleep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule